// File: doc/BRIEF.md
# Soft-Decision BCH Extra-Error Magnitude Solver

This block finishes a least-reliable-bits soft BCH decode over GF(2^8) for a double-error-correcting code (t = 2). It takes the two odd syndromes and the four candidate error locators chosen upstream. It then tries every binary assignment of error magnitudes to the candidates, one assignment per clock, using a 4-bit counter. For each assignment it forms the residual between the odd syndromes and the selected candidate contributions. A residual of zero means that every error sits on a selected candidate. A residual whose second term equals the cube of the first, with a nonzero first term, points to exactly one further error outside the candidate set. The location of that error is the discrete logarithm of the first residual term, and a constant table supplies it.

A pulse on `start_i` captures the syndromes and the locators. The block spends t−1 cycles raising its per-candidate columns from β to β^3, β^5 and so on, and then sweeps all 2^(2t) patterns. When the sweep ends it pulses `done_o` and presents the chosen magnitude pattern, the extra-error flag and location, or a failure flag. These results stay on the outputs until the next search completes.

Top module: `bch_cems`

## Requirements
- R1: After reset, `done_o`, `fail_o` and `extra_o` are 0, and `gamma_o` and `extra_loc_o` are 0.
- R2: `done_o` is high for exactly one cycle. It rises in the 17th cycle after the clock edge that accepts `start_i`, which is (t−1)+2^(2t) cycles.
- R3: `syn_i[7:0]` is S1 and `syn_i[15:8]` is S3. Candidate i is `loc_i[8i+7:8i]` and maps to `gamma_o[i]`. When some pattern gives an all-zero residual, `gamma_o` equals that pattern, with `extra_o`=0 and `fail_o`=0.
- R4: A pattern is a geometric match when δ3 = δ1^3 and δ1 ≠ 0, where δ1 = S1 + Σγβ and δ3 = S3 + Σγβ^3. The field uses α as a root of x^8+x^4+x^3+x^2+1. If the result is a geometric match, then `extra_o`=1 and `extra_loc_o` = log_α(δ1).
- R5: An all-zero residual pattern wins over any geometric match, even when the geometric match comes earlier in counter order.
- R6: When only geometric matches exist, the one with the lowest counter value is chosen.
- R7: If no pattern matches, `fail_o`=1, `extra_o`=0 and `gamma_o`=0.
- R8: A `start_i` pulse during a search is ignored. Both the result and the timing of `done_o` follow the accepted start.
- R9: The result outputs keep their values until the next `done_o`.
- R10: An error on all four candidates plus one more error outside them is fully resolved: `gamma_o`=4'b1111, `extra_o`=1, and `extra_loc_o` gives the outside location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a search when idle |
| syn_i | input | 16 | Odd syndromes {S3, S1} |
| loc_i | input | 32 | Four candidate locators, candidate 0 in the low byte |
| done_o | output | 1 | One-cycle end-of-search pulse |
| fail_o | output | 1 | No pattern matched |
| extra_o | output | 1 | One error outside the candidate set was found |
| extra_loc_o | output | 8 | Location of the outside error |
| gamma_o | output | 4 | Chosen magnitude pattern, bit per candidate |

## Verification
The two functions that can coincide in one search are the all-zero residual test and the geometric test. Whenever an exact pattern exists, every pattern that differs from it in a single bit leaves the residual of one candidate. That residual is always geometric, and it often comes earlier in counter order. The bench provokes this on purpose. It places errors only on high-numbered candidates, so that pattern 0 or a single-bit pattern matches geometrically before the exact pattern is reached. It then checks that the exact pattern is reported with `extra_o` low. Every outcome is also compared with an exhaustive reference search written in the bench.

// File: rtl/bch_cems_pkg.sv
package bch_cems_pkg;
  localparam int GF_M = 8;
  localparam logic [GF_M:0] GF_POLY = 9'h11D;
  localparam int GF_SIZE = 1 << GF_M;

  typedef enum logic [1:0] {ST_IDLE, ST_BUILD, ST_SEARCH} cems_state_e;

  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a, input logic [GF_M-1:0] b);
    logic [GF_M-1:0] acc;
    logic [GF_M-1:0] sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[GF_M-1] ? ((sh << 1) ^ GF_POLY[GF_M-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // log_alpha table, entry x at bits [x*GF_M +: GF_M]; entry 0 unused
  function automatic logic [GF_SIZE*GF_M-1:0] gf_log_table();
    logic [GF_SIZE*GF_M-1:0] tbl;
    logic [GF_M-1:0] p;
    tbl = '0;
    p   = GF_M'(1);
    for (int e = 0; e < GF_SIZE - 1; e++) begin
      tbl[int'(p)*GF_M +: GF_M] = GF_M'(e);
      p = gf_mul(p, GF_M'(2));
    end
    return tbl;
  endfunction
endpackage

// File: rtl/cems_matrix.sv
module cems_matrix
  import bch_cems_pkg::*;
#(
  parameter int T = 2,
  localparam int N = 2 * T
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [N*GF_M-1:0]     loc_i,
  output logic [N*T*GF_M-1:0]   mat_o
);
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [GF_M-1:0] sq_q;
    logic [GF_M-1:0] col_q [T];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sq_q <= '0;
        for (int j = 0; j < T; j++) col_q[j] <= '0;
      end else if (load_i) begin
        sq_q <= gf_mul(loc_i[i*GF_M +: GF_M], loc_i[i*GF_M +: GF_M]);
        for (int j = 0; j < T; j++) col_q[j] <= loc_i[i*GF_M +: GF_M];
      end else if (step_i) begin
        // column j climbs by beta^2 per step until it reaches beta^(2j+1)
        for (int j = 1; j < T; j++) col_q[j] <= gf_mul(col_q[j-1], sq_q);
      end
    end

    for (genvar j = 0; j < T; j++) begin : g_col
      assign mat_o[(i*T+j)*GF_M +: GF_M] = col_q[j];
    end
  end
endmodule

// File: rtl/cems_delta.sv
module cems_delta
  import bch_cems_pkg::*;
#(
  parameter int T = 2,
  localparam int N = 2 * T
) (
  input  logic [T*GF_M-1:0]   syn_i,
  input  logic [N*T*GF_M-1:0] mat_i,
  input  logic [N-1:0]        gamma_i,
  output logic                zero_o,
  output logic                geo_o,
  output logic [GF_M-1:0]     log_o
);
  localparam logic [GF_SIZE*GF_M-1:0] LOG_TBL = gf_log_table();

  logic [GF_M-1:0] d [T];
  logic [GF_M-1:0] d1_sq;

  always_comb begin
    for (int j = 0; j < T; j++) begin
      d[j] = syn_i[j*GF_M +: GF_M];
      for (int i = 0; i < N; i++)
        if (gamma_i[i]) d[j] = d[j] ^ mat_i[(i*T+j)*GF_M +: GF_M];
    end
  end

  always_comb begin
    zero_o = 1'b1;
    for (int j = 0; j < T; j++) if (d[j] != '0) zero_o = 1'b0;
  end

  assign d1_sq = gf_mul(d[0], d[0]);

  always_comb begin
    geo_o = (d[0] != '0);
    for (int a = 0; a < T - 1; a++)
      if (gf_mul(d[a], d1_sq) != d[a+1]) geo_o = 1'b0;
  end

  assign log_o = LOG_TBL[int'(d[0])*GF_M +: GF_M];
endmodule

// File: rtl/bch_cems.sv
module bch_cems
  import bch_cems_pkg::*;
#(
  parameter int T = 2,
  localparam int N = 2 * T,
  localparam int SW = $clog2(T) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [T*GF_M-1:0] syn_i,
  input  logic [N*GF_M-1:0] loc_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              extra_o,
  output logic [GF_M-1:0]   extra_loc_o,
  output logic [N-1:0]      gamma_o
);
  cems_state_e state_q;
  logic [SW-1:0]       step_q;
  logic [N-1:0]        pat_q;
  logic [T*GF_M-1:0]   syn_q;
  logic                hit_z_q, hit_g_q;
  logic [N-1:0]        z_pat_q, g_pat_q;
  logic [GF_M-1:0]     g_loc_q;

  logic [N*T*GF_M-1:0] mat;
  logic                zero, geo;
  logic [GF_M-1:0]     dlog;
  logic                load, step, srch, last;
  logic                z_any, g_any;
  logic [N-1:0]        z_pat, g_pat;
  logic [GF_M-1:0]     g_loc;

  assign load = (state_q == ST_IDLE) && start_i;
  assign step = (state_q == ST_BUILD);
  assign srch = (state_q == ST_SEARCH);
  assign last = srch && (pat_q == {N{1'b1}});

  cems_matrix #(.T(T)) u_mat (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .loc_i (loc_i), .mat_o (mat)
  );

  cems_delta #(.T(T)) u_delta (
    .syn_i (syn_q), .mat_i(mat), .gamma_i(pat_q),
    .zero_o(zero), .geo_o(geo), .log_o(dlog)
  );

  // first hit in counter order, including the current pattern
  assign z_any = hit_z_q | (srch & zero);
  assign z_pat = hit_z_q ? z_pat_q : pat_q;
  assign g_any = hit_g_q | (srch & geo);
  assign g_pat = hit_g_q ? g_pat_q : pat_q;
  assign g_loc = hit_g_q ? g_loc_q : dlog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      pat_q       <= '0;
      syn_q       <= '0;
      hit_z_q     <= 1'b0;
      hit_g_q     <= 1'b0;
      z_pat_q     <= '0;
      g_pat_q     <= '0;
      g_loc_q     <= '0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      extra_o     <= 1'b0;
      extra_loc_o <= '0;
      gamma_o     <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          syn_q   <= syn_i;
          pat_q   <= '0;
          step_q  <= '0;
          hit_z_q <= 1'b0;
          hit_g_q <= 1'b0;
          state_q <= ST_BUILD;
        end
        ST_BUILD: begin
          step_q <= step_q + 1'b1;
          if (step_q == SW'(T - 2)) state_q <= ST_SEARCH;
        end
        ST_SEARCH: begin
          hit_z_q <= z_any;
          z_pat_q <= z_pat;
          hit_g_q <= g_any;
          g_pat_q <= g_pat;
          g_loc_q <= g_loc;
          pat_q   <= pat_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            if (z_any) begin
              gamma_o     <= z_pat;
              extra_o     <= 1'b0;
              extra_loc_o <= '0;
              fail_o      <= 1'b0;
            end else if (g_any) begin
              gamma_o     <= g_pat;
              extra_o     <= 1'b1;
              extra_loc_o <= g_loc;
              fail_o      <= 1'b0;
            end else begin
              gamma_o     <= '0;
              extra_o     <= 1'b0;
              extra_loc_o <= '0;
              fail_o      <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_cems_chk.sv
module bch_cems_chk
  import bch_cems_pkg::*;
#(
  parameter int T = 2,
  localparam int N = 2 * T,
  localparam int LAT = (T - 1) + (1 << (2 * T))
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_o,
  input logic            fail_o,
  input logic            extra_o,
  input logic [GF_M-1:0] extra_loc_o,
  input logic [N-1:0]    gamma_o
);
  logic [15:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if ((since_q == '0 || done_o) && start_i) since_q <= 16'd1;
    else if (done_o) since_q <= '0;
    else if (since_q != '0) since_q <= since_q + 16'd1;
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == 16'(LAT + 1));

  p_fail_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!extra_o && gamma_o == '0));

  p_extra_not_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_o |-> !fail_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(gamma_o) && $stable(fail_o) && $stable(extra_o) && $stable(extra_loc_o)));
endmodule

bind bch_cems bch_cems_chk #(.T(T)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .fail_o(fail_o), .extra_o(extra_o), .extra_loc_o(extra_loc_o), .gamma_o(gamma_o)
);

// File: tb/sim_bch_cems.sv
module sim_bch_cems;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] syn_i = '0;
  logic [31:0] loc_i = '0;
  logic        done_o, fail_o, extra_o;
  logic [7:0]  extra_loc_o;
  logic [3:0]  gamma_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  bch_cems u0 (.*);

  // ---------- independent field model ----------
  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (16'(a) << k);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h11D << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] apow(input int e);
    logic [7:0] r;
    r = 8'd1;
    for (int k = 0; k < (e % 255); k++) r = fmul(r, 8'd2);
    return r;
  endfunction

  function automatic logic [7:0] alog(input logic [7:0] x);
    for (int e = 0; e < 255; e++) if (apow(e) == x) return 8'(e);
    return 8'd0;
  endfunction

  // exhaustive reference following R3..R7
  task automatic ref_solve(input logic [7:0] s1, input logic [7:0] s3, input logic [31:0] locs,
                           output logic [3:0] eg, output logic ex, output logic [7:0] el,
                           output logic ef);
    logic zf, gf;
    logic [3:0] zp, gp;
    logic [7:0] gl, d1, d3, b;
    zf = 0; gf = 0; zp = 0; gp = 0; gl = 0;
    for (int p = 0; p < 16; p++) begin
      d1 = s1; d3 = s3;
      for (int i = 0; i < 4; i++) if (p[i]) begin
        b = locs[i*8 +: 8];
        d1 = d1 ^ b;
        d3 = d3 ^ fmul(b, fmul(b, b));
      end
      if (d1 == 0 && d3 == 0 && !zf) begin zf = 1; zp = 4'(p); end
      if (d1 != 0 && fmul(d1, fmul(d1, d1)) == d3 && !gf) begin
        gf = 1; gp = 4'(p); gl = alog(d1);
      end
    end
    if (zf)      begin eg = zp; ex = 0; el = 0;  ef = 0; end
    else if (gf) begin eg = gp; ex = 1; el = gl; ef = 0; end
    else         begin eg = 0;  ex = 0; el = 0;  ef = 1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cands(input int a, input int b, input int c, input int d);
    return {apow(d), apow(c), apow(b), apow(a)};
  endfunction

  // start a search and count cycles to done
  task automatic launch(input logic [7:0] s1, input logic [7:0] s3, input logic [31:0] locs,
                        output int lat);
    @(negedge clk_i);
    syn_i = {s3, s1}; loc_i = locs; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    do begin @(negedge clk_i); lat++; end while (!done_o && lat < 100);
  endtask

  task automatic run_case(input string req, input logic [7:0] s1, input logic [7:0] s3,
                          input logic [31:0] locs);
    int lat;
    logic [3:0] eg; logic ex, ef; logic [7:0] el;
    ref_solve(s1, s3, locs, eg, ex, el, ef);
    launch(s1, s3, locs, lat);
    chk({req, " R2 latency"}, lat, 17);
    chk({req, " gamma"}, int'(gamma_o), int'(eg));
    chk({req, " extra"}, int'(extra_o), int'(ex));
    chk({req, " extra_loc"}, int'(extra_loc_o), int'(el));
    chk({req, " fail"}, int'(fail_o), int'(ef));
  endtask

  function automatic logic [7:0] s_of(input int e0, input int e1, input int e2, input int e3,
                                      input int e4, input int n, input int pw);
    logic [7:0] s;
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    s = '0;
    for (int k = 0; k < n; k++) s = s ^ apow(e[k] * pw);
    return s;
  endfunction

  task automatic t_reset();
    chk("R1 done", int'(done_o), 0);
    chk("R1 fail", int'(fail_o), 0);
    chk("R1 extra", int'(extra_o), 0);
    chk("R1 gamma", int'(gamma_o), 0);
    chk("R1 extra_loc", int'(extra_loc_o), 0);
  endtask

  task automatic t_in_set();  // R3: errors on candidates 1 and 3
    run_case("R3", s_of(17, 200, 0, 0, 0, 2, 1), s_of(17, 200, 0, 0, 0, 2, 3), cands(3, 17, 40, 200));
    chk("R3 pattern", int'(gamma_o), 4'b1010);
    chk("R3 extra", int'(extra_o), 0);
  endtask

  task automatic t_zero_wins();  // R5: pattern 0 is geometric, 1000 is exact
    run_case("R5", apow(250), apow(750), cands(11, 22, 33, 250));
    chk("R5 pattern", int'(gamma_o), 4'b1000);
    chk("R5 extra", int'(extra_o), 0);
  endtask

  task automatic t_outside();  // R4
    run_case("R4", s_of(9, 60, 77, 0, 0, 3, 1), s_of(9, 60, 77, 0, 0, 3, 3), cands(5, 9, 60, 130));
  endtask

  task automatic t_first_geo();  // R6: lone outside error, pattern 0 first
    run_case("R6", apow(33), apow(99), cands(1, 2, 4, 8));
    chk("R6 pattern", int'(gamma_o), 0);
    chk("R6 extra", int'(extra_o), 1);
    chk("R6 extra_loc", int'(extra_loc_o), 33);
  endtask

  task automatic t_five();  // R10
    run_case("R10", s_of(12, 45, 99, 180, 101, 5, 1), s_of(12, 45, 99, 180, 101, 5, 3),
             cands(12, 45, 99, 180));
    chk("R10 pattern", int'(gamma_o), 4'b1111);
    chk("R10 extra", int'(extra_o), 1);
    chk("R10 extra_loc", int'(extra_loc_o), 101);
  endtask

  task automatic t_fail();  // R7
    run_case("R7a", 8'd1, 8'd0, 32'd0);
    chk("R7a fail", int'(fail_o), 1);
    run_case("R7b", 8'd0, 8'd5, 32'd0);
    chk("R7b fail", int'(fail_o), 1);
    chk("R7b gamma", int'(gamma_o), 0);
  endtask

  task automatic t_busy();  // R8
    int lat;
    @(negedge clk_i);
    syn_i = {apow(99), apow(33)}; loc_i = cands(1, 2, 4, 8); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk_i); lat++; end
    syn_i = 16'h0001; loc_i = 32'd0; start_i = 1'b1;
    @(negedge clk_i); lat++;
    start_i = 1'b0;
    do begin @(negedge clk_i); lat++; end while (!done_o && lat < 100);
    chk("R8 latency", lat, 17);
    chk("R8 fail", int'(fail_o), 0);
    chk("R8 extra_loc", int'(extra_loc_o), 33);
  endtask

  task automatic t_hold();  // R9 and R2 pulse width
    logic [3:0] g; logic [7:0] l; logic x;
    run_case("R9", apow(250), apow(750), cands(11, 22, 250, 33));
    g = gamma_o; l = extra_loc_o; x = extra_o;
    @(negedge clk_i);
    chk("R2 pulse", int'(done_o), 0);
    repeat (5) @(negedge clk_i);
    chk("R9 gamma", int'(gamma_o), int'(g));
    chk("R9 extra", int'(extra_o), int'(x));
    chk("R9 extra_loc", int'(extra_loc_o), int'(l));
    chk("R9 gamma exact", int'(gamma_o), 4'b0100);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_in_set();
    t_zero_wins();
    t_outside();
    t_first_geo();
    t_five();
    t_fail();
    t_busy();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule